// File: doc/BRIEF.md
# Two-Level Wildcard Pattern Matcher

This block recognises patterns made of fixed sub-strings separated by "any text" gaps. A first automaton (the front stage) reads one input byte per cycle. It moves through a table-driven state graph that spots the individual sub-strings. Each cycle it produces a small symbol: nonzero when its new state ends a sub-string, zero otherwise.

A second automaton (the back stage) reads that symbol stream one cycle later. Its own table tracks which sub-strings have already appeared and in what order. When a full pattern is complete, its per-state output table raises a nonzero match vector. Because the gaps are handled over the short symbol stream rather than over raw bytes, the wildcard combinations do not multiply the front stage's state count.

Every table is a register array that software loads through a write-only configuration port. Compiling patterns into table contents is done outside the block. Bytes are first reduced to a character class, so the front-stage table stays small.

Top module: `cascade_dfa_matcher`

## Requirements
- R1: Reset clears both state registers to 0, clears the pending symbol to 0, holds `mv_valid` low and `mv_out` at zero.
- R2: A cycle with `cfg_we` high writes `cfg_data` (low bits) into one table. The table is chosen by `cfg_sel`:
  - 0: byte class table, address = byte value.
  - 1: front next state, address = {state, class}.
  - 2: front symbol, address = state.
  - 3: back next state, address = {state, symbol}.
  - 4: match vector, address = state.
  A rewrite changes how later input is matched.
- R3: Each cycle with `in_valid` high, the front state becomes the table entry at {current state, class of `in_byte`}. A byte that breaks a partial sub-string restarts the search, and a new sub-string may begin on the very next byte.
- R4: A cycle with `in_valid` low leaves both automata unchanged, whatever `in_byte` carries.
- R5: The symbol of the front stage's new state is registered and consumed by the back stage on the following clock. Symbol value 0 means "no sub-string ended".
- R6: A zero symbol leaves the back-stage state unchanged.
- R7: `mv_valid` pulses for one cycle when the back stage moves on a nonzero symbol into a state whose match vector is nonzero. `mv_out` then carries that vector and is zero in every other cycle. The strobe is seen one clock after the final byte's accepting edge, so two edges after the final byte is presented.
- R8: A pattern matches when its sub-strings appear in order, even with another pattern's sub-strings interleaved between them. Sub-strings in the reverse order do not match.
- R9: Each later completion of the closing sub-string strobes the match again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 3 | Table selector (R2 encoding) |
| cfg_addr | input | CFG_AW | Table entry address |
| cfg_data | input | CFG_DW | Table entry value, low bits used |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Input byte |
| mv_valid | output | 1 | Match strobe |
| mv_out | output | MV_W | Match vector, zero when not strobing |

## Verification
The bench builds the block with its default parameters: 16 front states, 16 byte classes, 8 back states, 3-bit symbols and a 2-bit match vector. This is enough room for two two-part patterns, "AB…CD" and "MN…PQ", plus back states that remember both openings at once. With that set, the bench can exercise the following cases:
- interleaved and reversed sub-string orders;
- a repeated closing sub-string;
- an invalid cycle carrying a pattern byte;
- a mid-stream reset;
- a live remap of the class table.

// File: rtl/cascade_dfa_matcher.sv
module cascade_dfa_matcher #(
  parameter int MS_W  = 4,
  parameter int CLS_W = 4,
  parameter int SS_W  = 3,
  parameter int SYM_W = 3,
  parameter int MV_W  = 2,
  localparam int MA_W   = MS_W + CLS_W,
  localparam int SA_W   = SS_W + SYM_W,
  localparam int AW0    = (MA_W > 8) ? MA_W : 8,
  localparam int CFG_AW = (SA_W > AW0) ? SA_W : AW0,
  localparam int DW0    = (CLS_W > MS_W) ? CLS_W : MS_W,
  localparam int DW1    = (SYM_W > DW0) ? SYM_W : DW0,
  localparam int DW2    = (SS_W > DW1) ? SS_W : DW1,
  localparam int CFG_DW = (MV_W > DW2) ? MV_W : DW2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_data,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              mv_valid,
  output logic [MV_W-1:0]   mv_out
);
  localparam int M_DEPTH = 1 << MA_W;
  localparam int S_DEPTH = 1 << SA_W;

  logic [CLS_W-1:0] cls_tab [256];
  logic [MS_W-1:0]  fr_nxt  [M_DEPTH];
  logic [SYM_W-1:0] fr_sym  [1 << MS_W];
  logic [SS_W-1:0]  bk_nxt  [S_DEPTH];
  logic [MV_W-1:0]  bk_vec  [1 << SS_W];

  logic [MS_W-1:0]  m_st;
  logic [SS_W-1:0]  s_st;
  logic [SYM_W-1:0] sym_q;

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: cls_tab[cfg_addr[7:0]]      <= cfg_data[CLS_W-1:0];
        3'd1: fr_nxt[cfg_addr[MA_W-1:0]]  <= cfg_data[MS_W-1:0];
        3'd2: fr_sym[cfg_addr[MS_W-1:0]]  <= cfg_data[SYM_W-1:0];
        3'd3: bk_nxt[cfg_addr[SA_W-1:0]]  <= cfg_data[SS_W-1:0];
        3'd4: bk_vec[cfg_addr[SS_W-1:0]]  <= cfg_data[MV_W-1:0];
        default: ;
      endcase
    end
  end

  wire [CLS_W-1:0] cls_w  = cls_tab[in_byte];
  wire [MS_W-1:0]  m_nx   = fr_nxt[{m_st, cls_w}];
  wire [SS_W-1:0]  s_nx   = bk_nxt[{s_st, sym_q}];
  wire [MV_W-1:0]  vec_nx = bk_vec[s_nx];
  wire             adv    = (sym_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st     <= '0;
      sym_q    <= '0;
      s_st     <= '0;
      mv_valid <= 1'b0;
      mv_out   <= '0;
    end else begin
      if (in_valid) begin
        m_st  <= m_nx;
        sym_q <= fr_sym[m_nx];
      end else begin
        sym_q <= '0;
      end
      if (adv) s_st <= s_nx;
      mv_valid <= adv && (vec_nx != '0);
      mv_out   <= adv ? vec_nx : '0;
    end
  end

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(m_st));
  a_r5_sym_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q != '0) |-> $past(in_valid));
  a_r6_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_q == '0) |=> $stable(s_st));
  a_r7_strobe_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_out != '0));
  a_r7_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mv_valid |-> (mv_out == '0));
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> $past(sym_q != '0));
endmodule

// File: tb/test_cascade_dfa_matcher.sv
module test_cascade_dfa_matcher;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_addr = '0;
  logic [3:0] cfg_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       mv_valid;
  logic [1:0] mv_out;

  int n_chk = 0, n_bad = 0, cyc = 0, hits = 0, hit_cyc = 0, last_cyc = 0;
  logic [1:0] last_mv = '0;

  cascade_dfa_matcher i_cascade_dfa_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .in_valid(in_valid),
    .in_byte(in_byte), .mv_valid(mv_valid), .mv_out(mv_out));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (mv_valid) begin
    hits = hits + 1; last_mv = mv_out; hit_cyc = cyc;
  end

  always @(posedge clk) if (cyc == 50000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cls_of(int b);
    case (b)
      "A": return 1; "B": return 2; "C": return 3; "D": return 4;
      "M": return 5; "N": return 6; "P": return 7; "Q": return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int fr_next(int s, int c);
    if (s == 1 && c == 2) return 2;
    if (s == 3 && c == 4) return 4;
    if (s == 5 && c == 6) return 6;
    if (s == 7 && c == 8) return 8;
    if (c == 1) return 1;
    if (c == 3) return 3;
    if (c == 5) return 5;
    if (c == 7) return 7;
    return 0;
  endfunction

  function automatic int fr_symbol(int s);
    case (s) 2: return 1; 4: return 2; 6: return 3; 8: return 4; default: return 0; endcase
  endfunction

  function automatic int flags_of(int s);
    case (s) 1: return 1; 2: return 1; 3: return 2; 4: return 2;
      5: return 3; 6: return 3; 7: return 3; default: return 0; endcase
  endfunction

  function automatic int plain_st(int f);
    case (f) 1: return 1; 2: return 3; 3: return 5; default: return 0; endcase
  endfunction

  function automatic int bk_next(int s, int y);
    int f = flags_of(s);
    case (y)
      1: return plain_st(f | 1);
      3: return plain_st(f | 2);
      2: if (f[0]) return (f == 3) ? 6 : 2; else return plain_st(f);
      4: if (f[1]) return (f == 3) ? 7 : 4; else return plain_st(f);
      default: return s;
    endcase
  endfunction

  function automatic int vec_of(int s);
    case (s) 2: return 1; 6: return 1; 4: return 2; 7: return 2; default: return 0; endcase
  endfunction

  task automatic wr(int sel, int addr, int data);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_addr = 8'(addr); cfg_data = 4'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_tables();
    for (int b = 0; b < 256; b++) wr(0, b, cls_of(b));
    for (int s = 0; s < 16; s++)
      for (int c = 0; c < 16; c++) wr(1, s * 16 + c, fr_next(s, c));
    for (int s = 0; s < 16; s++) wr(2, s, fr_symbol(s));
    for (int s = 0; s < 8; s++)
      for (int y = 0; y < 8; y++) wr(3, s * 8 + y, bk_next(s, y));
    for (int s = 0; s < 8; s++) wr(4, s, vec_of(s));
  endtask

  task automatic push(byte b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    last_cyc = cyc; in_valid = 1'b0;
  endtask

  task automatic idle(int n, byte junk);
    in_valid = 1'b0; in_byte = junk;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(string s);
    for (int i = 0; i < s.len(); i++) push(s[i]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; @(negedge clk);
    check("R1 strobe in reset", int'(mv_valid), 0);
    check("R1 vector in reset", int'(mv_out), 0);
    rst_n = 1'b1; @(negedge clk);
    check("R1 strobe after reset", int'(mv_valid), 0);
  endtask

  task automatic t_interleaved();
    int base;
    do_reset(); base = hits;
    send("ABMNCD"); idle(4, "Q");
    check("R8 interleaved hits", hits - base, 1);
    check("R8 interleaved vector", int'(last_mv), 1);
    check("R7 strobe latency", hit_cyc - last_cyc, 1);
    check("R7 vector zero after strobe", int'(mv_out), 0);
  endtask

  task automatic t_second_pattern();
    int base;
    do_reset(); base = hits;
    send("ABMNPQ"); idle(4, "x");
    check("R8 second pattern hits", hits - base, 1);
    check("R8 second pattern vector", int'(last_mv), 2);
  endtask

  task automatic t_reverse();
    int base;
    do_reset(); base = hits;
    send("CDAB"); idle(4, "x");
    check("R8 reverse order no match", hits - base, 0);
  endtask

  task automatic t_repeat();
    int base;
    do_reset(); base = hits;
    send("ABCD"); idle(2, "x");
    check("R9 first completion", hits - base, 1);
    send("CD"); idle(4, "x");
    check("R9 repeated completion", hits - base, 2);
    check("R9 repeated vector", int'(last_mv), 1);
  endtask

  task automatic t_broken();
    int base;
    do_reset(); base = hits;
    send("AxBCD"); idle(4, "x");
    check("R3 broken sub-string no match", hits - base, 0);
    send("AAB"); send("CD"); idle(4, "x");
    check("R3 restart on repeated opener", hits - base, 1);
  endtask

  task automatic t_idle_ignored();
    int base;
    do_reset(); base = hits;
    push("A"); idle(3, "Q"); push("B");
    in_valid = 1'b0; in_byte = "C"; @(negedge clk);
    in_byte = "D"; @(negedge clk);
    idle(3, "x");
    check("R4 invalid bytes ignored", hits - base, 0);
    send("CD"); idle(4, "x");
    check("R4 state kept across idle", hits - base, 1);
    check("R5 zero symbols hold back stage", int'(last_mv), 1);
  endtask

  task automatic t_mid_reset();
    int base;
    do_reset(); base = hits;
    send("AB"); idle(2, "x");
    do_reset();
    send("CD"); idle(4, "x");
    check("R1 reset forgets opener", hits - base, 0);
  endtask

  task automatic t_remap();
    int base;
    do_reset(); base = hits;
    send("ZBCD"); idle(4, "x");
    check("R2 unmapped byte no match", hits - base, 0);
    wr(0, "Z", 1);
    send("ZBCD"); idle(4, "x");
    check("R2 remapped class match", hits - base, 1);
    wr(0, "Z", 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    load_tables();
    t_interleaved();
    t_second_pattern();
    t_reverse();
    t_repeat();
    t_broken();
    t_idle_ignored();
    t_mid_reset();
    t_remap();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule